// File: doc/BRIEF.md
# Legacy x86 Instruction Field Parser

This block takes an x86-64 instruction one byte at a time and splits it into its fields. It accepts a byte on every clock where `in_valid` is high. The order of the fields is: legacy prefixes, an optional REX byte, a one- or two-byte opcode, an optional ModR/M byte, an optional SIB byte, displacement bytes and immediate bytes. The opcode decides whether ModR/M and an immediate follow. Mod and R/M decide whether SIB follows, and Mod, R/M and the SIB base decide how many displacement bytes follow.

When the last byte of an instruction arrives, the parser emits one decoded record for a single cycle. The record holds:
- the prefix groups seen and the REX bits;
- the opcode;
- the direction and operand size;
- the ModR/M and SIB fields;
- the sign-extended displacement and immediate;
- the total byte count.

A sequence the parser cannot accept also ends in a record, with the illegal flag set. This covers a repeated prefix group, an opcode outside the supported set, and an instruction that runs past the length limit. After such a record the parser expects the first byte of a new instruction.

Supported opcodes:
- one-byte 0x00–0x03 and 0x88–0x8B: ModR/M, no immediate;
- 0x04 and 0x05: immediate only;
- 0xC6 and 0xC7: ModR/M and immediate;
- 0x90: no further bytes;
- two-byte 0x0F 0xAF: ModR/M;
- 0x0F 0x05: no further bytes.

Top module: `ixp_parser`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Legacy prefixes are grouped and each group sets one bit of `out_pfx`:
  - bit 0 is lock/repeat (F0, F2, F3);
  - bit 1 is segment (26, 2E, 36, 3E, 64, 65);
  - bit 2 is operand size (66);
  - bit 3 is address size (67).
  A prefix whose group was already seen in the same instruction ends it at once as illegal, and the next byte starts a new instruction.
- R3: A first opcode byte of 0F makes the next byte a second opcode byte. `out_opcode` is {8'h0F, second byte} for a two-byte opcode and {8'h00, byte} for a one-byte opcode. An opcode outside the supported set ends the instruction as illegal.
- R4: When bit 0 of the final opcode byte is 0, `out_size` is 0 (8 bits).
- R5: When bit 0 of the final opcode byte is 1, `out_size` is chosen in this order:
  - 3 (64 bits) when REX.W (bit 3 of the REX byte) is set;
  - otherwise 1 (16 bits) when a 66 prefix is present;
  - otherwise 2 (32 bits).
- R6: `out_reg_dst` equals bit 1 of the final opcode byte. 1 means REG is the destination.
- R7: The ModR/M byte is split into `out_mod` (bits 7:6), `out_reg` (bits 5:3) and `out_rm` (bits 2:0), and `out_has_modrm` is set.
- R8: A SIB byte follows exactly when Mod != 3 and R/M = 4. It sets `out_has_sib`, `out_index` (bits 5:3) and `out_base` (bits 2:0), and `out_scale` = 1 << SS (bits 7:6).
- R9: The displacement length is chosen as follows, stored little-endian in `out_disp`:
  - Mod=1 gives 1 byte, sign-extended to 32 bits;
  - Mod=2 gives 4 bytes;
  - Mod=0 gives 4 bytes when, without SIB, R/M=5, or when SIB is present and its base is 5;
  - otherwise there is no displacement and `out_disp` is 0.
- R10: Immediate length is 1 byte for 8-bit size, 2 bytes for 16-bit size and 4 bytes otherwise. It is stored little-endian in `out_imm`, and 1- and 2-byte immediates are sign-extended.
- R11: A byte 40–4F counts as REX only when the opcode follows it directly. A later REX replaces an earlier one, and a legacy prefix after a REX byte discards it. `out_rex_vld` and `out_rex` (low nibble) report the REX byte in effect.
- R12: If the byte at position `MAX_LEN` (15) does not complete the instruction, the instruction ends as illegal with `out_len` = 15.
- R13: The record appears with `out_valid` high for exactly one cycle, the cycle after the edge that accepted the final byte. `out_len` counts every accepted byte of the instruction. `out_valid` stays 0 while bytes are still outstanding or `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| out_valid | output | 1 | Decoded record valid (one cycle) |
| out_illegal | output | 1 | Instruction ended as illegal |
| out_len | output | 4 | Bytes in the instruction |
| out_pfx | output | 4 | Prefix groups seen |
| out_rex_vld | output | 1 | REX byte in effect |
| out_rex | output | 4 | REX W, R, X, B bits |
| out_opcode | output | 16 | Escape byte and opcode byte |
| out_reg_dst | output | 1 | REG field is the destination |
| out_size | output | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 |
| out_has_modrm | output | 1 | ModR/M present |
| out_mod | output | 2 | Mod field |
| out_reg | output | 3 | REG field |
| out_rm | output | 3 | R/M field |
| out_has_sib | output | 1 | SIB present |
| out_scale | output | 4 | Index scale factor |
| out_index | output | 3 | SIB index |
| out_base | output | 3 | SIB base |
| out_disp | output | 32 | Sign-extended displacement |
| out_imm | output | 32 | Sign-extended immediate |

## Verification
The bench builds the parser with `MAX_LEN` at its default of 15, the architectural limit. At that value a fully legal-looking instruction can exceed the limit:
- four prefixes;
- REX;
- an opcode with ModR/M, SIB and 32-bit displacement;
- a 32-bit immediate.

That is 16 bytes, so the cap is reached both on real field sequences and on a run of REX bytes. Back-to-back instructions, idle gaps between bytes and recovery after each kind of illegal ending are all reachable with the default setting.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

    localparam int DISP_W = 32;
    localparam int IMM_W  = 32;

    typedef enum logic [2:0] {
        S_PFX, S_OP2, S_MODRM, S_SIB, S_DISP, S_IMM
    } pstate_e;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } opsz_e;

    typedef struct packed {
        logic known;
        logic needs_modrm;
        logic needs_imm;
    } opinfo_t;

    typedef struct packed {
        logic        illegal;
        logic [3:0]  pfx;
        logic        rex_vld;
        logic [3:0]  rex;
        logic [15:0] opcode;
        logic        reg_dst;
        opsz_e       size;
        logic        has_modrm;
        logic [7:0]  modrm;
        logic        has_sib;
        logic [7:0]  sib;
        logic [31:0] disp;
        logic [31:0] imm;
    } rec_t;

    // Supported opcode subset: {known, ModR/M follows, immediate follows}
    function automatic opinfo_t op_lookup(input logic two, input logic [7:0] b);
        opinfo_t r;
        r = '0;
        if (!two) begin
            if (b[7:2] == 6'b000000 || b[7:2] == 6'b100010) r = '{1'b1, 1'b1, 1'b0};
            else if (b == 8'h04 || b == 8'h05)              r = '{1'b1, 1'b0, 1'b1};
            else if (b == 8'hC6 || b == 8'hC7)              r = '{1'b1, 1'b1, 1'b1};
            else if (b == 8'h90)                            r = '{1'b1, 1'b0, 1'b0};
        end else begin
            if (b == 8'hAF)      r = '{1'b1, 1'b1, 1'b0};
            else if (b == 8'h05) r = '{1'b1, 1'b0, 1'b0};
        end
        return r;
    endfunction

    // {is legacy prefix, group index}
    function automatic logic [2:0] pfx_class(input logic [7:0] b);
        case (b)
            8'hF0, 8'hF2, 8'hF3:                      return 3'b100;
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 3'b101;
            8'h66:                                    return 3'b110;
            8'h67:                                    return 3'b111;
            default:                                  return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] disp_bytes(input logic [1:0] mode, input logic [2:0] sel);
        if (mode == 2'd1)                    return 3'd1;
        else if (mode == 2'd2)               return 3'd4;
        else if (mode == 2'd0 && sel == 3'd5) return 3'd4;
        else                                 return 3'd0;
    endfunction

    function automatic logic [31:0] widen(input logic [31:0] v, input logic [2:0] n);
        case (n)
            3'd1:    return {{24{v[7]}}, v[7:0]};
            3'd2:    return {{16{v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/ixp_prefix_unit.sv
module ixp_prefix_unit
    import ixp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       take,
    input  logic [7:0] byte_i,
    output logic       is_pfx_o,
    output logic       is_rex_o,
    output logic       dup_o,
    output logic [3:0] mask_o,
    output logic       rex_vld_o,
    output logic [3:0] rex_o
);

    logic [2:0] cls;
    logic [3:0] mask_q;
    logic       rex_vld_q;
    logic [3:0] rex_q;

    assign cls       = pfx_class(byte_i);
    assign is_pfx_o  = cls[2];
    assign is_rex_o  = (byte_i[7:4] == 4'h4);
    assign dup_o     = cls[2] && mask_q[cls[1:0]];
    assign mask_o    = mask_q;
    assign rex_vld_o = rex_vld_q;
    assign rex_o     = rex_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask_q    <= '0;
            rex_vld_q <= 1'b0;
            rex_q     <= '0;
        end else if (take) begin
            if (cls[2]) begin
                mask_q[cls[1:0]] <= 1'b1;
                rex_vld_q        <= 1'b0;
            end else if (is_rex_o) begin
                rex_vld_q <= 1'b1;
                rex_q     <= byte_i[3:0];
            end
        end
    end

    // R2: group bits only accumulate within an instruction
    a_r2_mask_grows: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R11: a legacy prefix discards any pending REX
    a_r11_rex_dropped: assert property (@(posedge clk) disable iff (rst)
        (take && is_pfx_o && !clr) |=> !rex_vld_q);

endmodule

// File: rtl/ixp_le_accum.sv
module ixp_le_accum #(
    parameter int W = 32,
    localparam int IW = $clog2(W / 8)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    byte_i,
    output logic [W-1:0]  acc_n
);

    logic [W-1:0] acc_q;

    always_comb begin
        acc_n = acc_q;
        if (load) acc_n[idx*8 +: 8] = byte_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else            acc_q <= acc_n;
    end

endmodule

// File: rtl/ixp_parser.sv
module ixp_parser
    import ixp_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [LEN_W-1:0] out_len,
    output logic [3:0]       out_pfx,
    output logic             out_rex_vld,
    output logic [3:0]       out_rex,
    output logic [15:0]      out_opcode,
    output logic             out_reg_dst,
    output logic [1:0]       out_size,
    output logic             out_has_modrm,
    output logic [1:0]       out_mod,
    output logic [2:0]       out_reg,
    output logic [2:0]       out_rm,
    output logic             out_has_sib,
    output logic [3:0]       out_scale,
    output logic [2:0]       out_index,
    output logic [2:0]       out_base,
    output logic [31:0]      out_disp,
    output logic [31:0]      out_imm
);

    pstate_e          st_q, st_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic [15:0]      op_q, op_n;
    opsz_e            size_q, size_n, size_new;
    logic             hm_q, hm_n, hs_q, hs_n;
    logic [7:0]       modrm_q, modrm_n, sib_q, sib_n;
    logic [2:0]       dlen_q, dlen_n, ilen_q, ilen_n, ilen_new;
    logic [1:0]       idx_q, idx_n;
    logic             done, fail, take, do_op, finish;
    opinfo_t          info;

    logic       is_pfx, is_rex, dup, rex_vld;
    logic [3:0] pmask, rex;
    logic [DISP_W-1:0] disp_acc;
    logic [IMM_W-1:0]  imm_acc;

    rec_t             rec_q, rec_n;
    logic             valid_q;
    logic [LEN_W-1:0] olen_q;

    assign in_ready = 1'b1;
    assign finish   = done || fail;

    ixp_prefix_unit u_pfx (
        .clk(clk), .rst(rst), .clr(finish), .take(take), .byte_i(in_byte),
        .is_pfx_o(is_pfx), .is_rex_o(is_rex), .dup_o(dup),
        .mask_o(pmask), .rex_vld_o(rex_vld), .rex_o(rex)
    );

    ixp_le_accum #(.W(DISP_W)) u_disp (
        .clk(clk), .rst(rst), .clr(finish),
        .load(in_valid && st_q == S_DISP), .idx(idx_q), .byte_i(in_byte),
        .acc_n(disp_acc)
    );

    ixp_le_accum #(.W(IMM_W)) u_imm (
        .clk(clk), .rst(rst), .clr(finish),
        .load(in_valid && st_q == S_IMM), .idx(idx_q), .byte_i(in_byte),
        .acc_n(imm_acc)
    );

    assign info     = op_lookup(st_q == S_OP2, in_byte);
    assign size_new = !in_byte[0]           ? SZ8  :
                      (rex_vld && rex[3])   ? SZ64 :
                      pmask[2]              ? SZ16 : SZ32;
    assign ilen_new = (size_new == SZ8) ? 3'd1 : (size_new == SZ16) ? 3'd2 : 3'd4;
    assign len_n    = len_q + 1'b1;

    always_comb begin
        st_n = st_q;  op_n = op_q;  size_n = size_q;
        hm_n = hm_q;  modrm_n = modrm_q;  hs_n = hs_q;  sib_n = sib_q;
        dlen_n = dlen_q;  ilen_n = ilen_q;  idx_n = idx_q;
        done = 1'b0;  fail = 1'b0;  take = 1'b0;  do_op = 1'b0;
        if (in_valid) begin
            case (st_q)
                S_PFX: begin
                    if (is_pfx && dup)          fail = 1'b1;
                    else if (is_pfx || is_rex)  take = 1'b1;
                    else if (in_byte == 8'h0F) begin
                        op_n = 16'h0F00;
                        st_n = S_OP2;
                    end else begin
                        op_n  = {8'h00, in_byte};
                        do_op = 1'b1;
                    end
                end
                S_OP2: begin
                    op_n  = {8'h0F, in_byte};
                    do_op = 1'b1;
                end
                S_MODRM: begin
                    modrm_n = in_byte;
                    if (in_byte[7:6] != 2'd3 && in_byte[2:0] == 3'd4) begin
                        hs_n = 1'b1;
                        st_n = S_SIB;
                    end else begin
                        dlen_n = disp_bytes(in_byte[7:6], in_byte[2:0]);
                        if (dlen_n != 3'd0)      st_n = S_DISP;
                        else if (ilen_q != 3'd0) st_n = S_IMM;
                        else                     done = 1'b1;
                    end
                end
                S_SIB: begin
                    sib_n  = in_byte;
                    dlen_n = disp_bytes(modrm_q[7:6], in_byte[2:0]);
                    if (dlen_n != 3'd0)      st_n = S_DISP;
                    else if (ilen_q != 3'd0) st_n = S_IMM;
                    else                     done = 1'b1;
                end
                S_DISP: begin
                    idx_n = idx_q + 2'd1;
                    if (({1'b0, idx_q} + 3'd1) == dlen_q) begin
                        idx_n = 2'd0;
                        if (ilen_q != 3'd0) st_n = S_IMM;
                        else                done = 1'b1;
                    end
                end
                default: begin
                    idx_n = idx_q + 2'd1;
                    if (({1'b0, idx_q} + 3'd1) == ilen_q) done = 1'b1;
                end
            endcase
            if (do_op) begin
                if (!info.known) begin
                    fail = 1'b1;
                end else begin
                    size_n = size_new;
                    hm_n   = info.needs_modrm;
                    ilen_n = info.needs_imm ? ilen_new : 3'd0;
                    if (info.needs_modrm)    st_n = S_MODRM;
                    else if (info.needs_imm) st_n = S_IMM;
                    else                     done = 1'b1;
                end
            end
            if (!done && !fail && len_n == LEN_W'(MAX_LEN)) fail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || finish) begin
            st_q <= S_PFX;  len_q <= '0;  op_q <= '0;  size_q <= SZ8;
            hm_q <= 1'b0;  modrm_q <= '0;  hs_q <= 1'b0;  sib_q <= '0;
            dlen_q <= '0;  ilen_q <= '0;  idx_q <= '0;
        end else if (in_valid) begin
            st_q <= st_n;  len_q <= len_n;  op_q <= op_n;  size_q <= size_n;
            hm_q <= hm_n;  modrm_q <= modrm_n;  hs_q <= hs_n;  sib_q <= sib_n;
            dlen_q <= dlen_n;  ilen_q <= ilen_n;  idx_q <= idx_n;
        end
    end

    always_comb begin
        rec_n.illegal   = fail;
        rec_n.pfx       = pmask;
        rec_n.rex_vld   = rex_vld;
        rec_n.rex       = rex;
        rec_n.opcode    = op_n;
        rec_n.reg_dst   = op_n[1];
        rec_n.size      = size_n;
        rec_n.has_modrm = hm_n;
        rec_n.modrm     = modrm_n;
        rec_n.has_sib   = hs_n;
        rec_n.sib       = sib_n;
        rec_n.disp      = widen(disp_acc, dlen_n);
        rec_n.imm       = widen(imm_acc, ilen_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rec_q   <= '0;
            olen_q  <= '0;
        end else begin
            valid_q <= finish;
            if (finish) begin
                rec_q  <= rec_n;
                olen_q <= len_n;
            end
        end
    end

    assign out_valid     = valid_q;
    assign out_illegal   = rec_q.illegal;
    assign out_len       = olen_q;
    assign out_pfx       = rec_q.pfx;
    assign out_rex_vld   = rec_q.rex_vld;
    assign out_rex       = rec_q.rex;
    assign out_opcode    = rec_q.opcode;
    assign out_reg_dst   = rec_q.reg_dst;
    assign out_size      = rec_q.size;
    assign out_has_modrm = rec_q.has_modrm;
    assign out_mod       = rec_q.modrm[7:6];
    assign out_reg       = rec_q.modrm[5:3];
    assign out_rm        = rec_q.modrm[2:0];
    assign out_has_sib   = rec_q.has_sib;
    assign out_scale     = 4'b0001 << rec_q.sib[7:6];
    assign out_index     = rec_q.sib[5:3];
    assign out_base      = rec_q.sib[2:0];
    assign out_disp      = rec_q.disp;
    assign out_imm       = rec_q.imm;

    // R12: the in-flight byte count never reaches the cap
    a_r12_len_bound: assert property (@(posedge clk) disable iff (rst)
        len_q < LEN_W'(MAX_LEN));

    // R13: a record always carries at least one byte
    a_r13_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len != '0));

    // R4: byte-sized opcode gives 8-bit size
    a_r4_byte_size: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && !out_opcode[0]) |-> (out_size == 2'd0));

    // R5: 64-bit size only with REX.W and a wide opcode
    a_r5_wide: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_size == 2'd3) |-> (out_rex_vld && out_rex[3] && out_opcode[0]));

    // R8: SIB only for memory forms with R/M = 4
    a_r8_sib_cond: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_has_sib) |-> (out_mod != 2'd3 && out_rm == 3'd4));

    // R9: an 8-bit displacement is sign-extended
    a_r9_disp8_ext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_has_modrm && out_mod == 2'd1)
        |-> (out_disp[31:7] == '0 || out_disp[31:7] == '1));

endmodule

// File: tb/ixp_parser_test.sv
module ixp_parser_test;

    typedef logic [7:0] bq_t[$];

    typedef struct {
        bit          ill;
        int          len;
        logic [3:0]  pfx;
        logic        rexv;
        logic [3:0]  rex;
        logic [15:0] op;
        logic        rdst;
        logic [1:0]  size;
        logic        hm;
        logic [1:0]  mod;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic        hs;
        logic [3:0]  scale;
        logic [2:0]  idx;
        logic [2:0]  base;
        logic [31:0] disp;
        logic [31:0] imm;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_ready;
    logic        out_valid;
    logic        out_illegal;
    logic [3:0]  out_len;
    logic [3:0]  out_pfx;
    logic        out_rex_vld;
    logic [3:0]  out_rex;
    logic [15:0] out_opcode;
    logic        out_reg_dst;
    logic [1:0]  out_size;
    logic        out_has_modrm;
    logic [1:0]  out_mod;
    logic [2:0]  out_reg;
    logic [2:0]  out_rm;
    logic        out_has_sib;
    logic [3:0]  out_scale;
    logic [2:0]  out_index;
    logic [2:0]  out_base;
    logic [31:0] out_disp;
    logic [31:0] out_imm;

    int n_vec  = 0;
    int n_fail = 0;
    bit summary_done = 0;

    ixp_parser uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int grp_of(input logic [7:0] b);
        if (b == 8'hF0 || b == 8'hF2 || b == 8'hF3) return 0;
        if (b == 8'h26 || b == 8'h2E || b == 8'h36 || b == 8'h3E || b == 8'h64 || b == 8'h65) return 1;
        if (b == 8'h66) return 2;
        if (b == 8'h67) return 3;
        return -1;
    endfunction

    function automatic int dsel(input logic [1:0] m, input logic [2:0] r);
        if (m == 1) return 1;
        if (m == 2) return 4;
        if (m == 0 && r == 5) return 4;
        return 0;
    endfunction

    // Behavioural reference parser
    function automatic exp_t model(input bq_t q);
        exp_t e;
        int p, g, db, ib;
        logic [7:0] b;
        bit known, hasm, hasi;
        e = '{default: '0};
        e.scale = 4'd1;
        p = 0;
        while (1) begin
            if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
            b = q[p];
            g = grp_of(b);
            if (g >= 0) begin
                p++;
                if (e.pfx[g]) begin e.ill = 1; e.len = p; return e; end
                e.pfx[g] = 1'b1;
                e.rexv = 1'b0;
            end else if (b >= 8'h40 && b <= 8'h4F) begin
                p++;
                e.rexv = 1'b1;
                e.rex = b[3:0];
            end else break;
        end
        p++;
        if (b == 8'h0F) begin
            if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
            b = q[p]; p++;
            e.op = {8'h0F, b};
        end else e.op = {8'h00, b};
        known = 0; hasm = 0; hasi = 0;
        case (e.op)
            16'h0000, 16'h0001, 16'h0002, 16'h0003,
            16'h0088, 16'h0089, 16'h008A, 16'h008B,
            16'h0FAF:                    begin known = 1; hasm = 1; end
            16'h0004, 16'h0005:          begin known = 1; hasi = 1; end
            16'h00C6, 16'h00C7:          begin known = 1; hasm = 1; hasi = 1; end
            16'h0090, 16'h0F05:          known = 1;
            default:                     known = 0;
        endcase
        if (!known) begin e.ill = 1; e.len = p; return e; end
        e.rdst = e.op[1];
        if (!e.op[0])                e.size = 0;
        else if (e.rexv && e.rex[3]) e.size = 3;
        else if (e.pfx[2])           e.size = 1;
        else                         e.size = 2;
        ib = !hasi ? 0 : (e.size == 0) ? 1 : (e.size == 1) ? 2 : 4;
        db = 0;
        if (hasm) begin
            if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
            b = q[p]; p++;
            e.hm = 1; e.mod = b[7:6]; e.rg = b[5:3]; e.rm = b[2:0];
            if (e.mod != 3 && e.rm == 4) begin
                if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
                b = q[p]; p++;
                e.hs = 1; e.scale = 4'd1 << b[7:6]; e.idx = b[5:3]; e.base = b[2:0];
                db = dsel(e.mod, e.base);
            end else db = dsel(e.mod, e.rm);
        end
        for (int k = 0; k < db; k++) begin
            if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
            e.disp[8*k +: 8] = q[p]; p++;
        end
        if (db == 1) e.disp = {{24{e.disp[7]}}, e.disp[7:0]};
        for (int k = 0; k < ib; k++) begin
            if (p >= 15) begin e.ill = 1; e.len = 15; return e; end
            e.imm[8*k +: 8] = q[p]; p++;
        end
        if (ib == 1) e.imm = {{24{e.imm[7]}}, e.imm[7:0]};
        if (ib == 2) e.imm = {{16{e.imm[15]}}, e.imm[15:0]};
        e.len = p;
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        chk("R13", "out_valid at end", out_valid, 1);
        chk(tag, "illegal", out_illegal, e.ill);
        chk("R13", "length", out_len, e.len);
        if (!e.ill) begin
            chk("R2", "prefix groups", out_pfx, e.pfx);
            chk("R11", "rex valid", out_rex_vld, e.rexv);
            if (e.rexv) chk("R11", "rex bits", out_rex, e.rex);
            chk("R3", "opcode", out_opcode, e.op);
            chk("R6", "reg_dst", out_reg_dst, e.rdst);
            chk(e.op[0] ? "R5" : "R4", "size", out_size, e.size);
            chk("R7", "has_modrm", out_has_modrm, e.hm);
            chk("R7", "mod/reg/rm", {out_mod, out_reg, out_rm}, {e.mod, e.rg, e.rm});
            chk("R8", "has_sib", out_has_sib, e.hs);
            chk("R8", "scale/index/base", {out_scale, out_index, out_base}, {e.scale, e.idx, e.base});
            chk("R9", "disp", out_disp, e.disp);
            chk("R10", "imm", out_imm, e.imm);
        end
    endtask

    task automatic send(input bq_t q, input string tag, input bit gaps);
        exp_t e;
        e = model(q);
        for (int i = 0; i < e.len; i++) begin
            if (gaps && i > 0) begin
                in_valid = 1'b0;
                @(posedge clk); #2;
                chk("R13", "idle out_valid", out_valid, 0);
            end
            in_valid = 1'b1;
            in_byte  = q[i];
            @(posedge clk); #2;
            if (i == e.len - 1) compare(e, tag);
            else chk("R13", "mid out_valid", out_valid, 0);
        end
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        bq_t rexrun;
        rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset in_ready", in_ready, 1);
        @(posedge clk); #2;
        chk("R1", "idle out_valid", out_valid, 0);

        send('{8'h90}, "R3", 0);
        send('{8'h01, 8'hD8}, "R6", 0);
        send('{8'h03, 8'h04, 8'h88}, "R8", 0);
        send('{8'h8B, 8'h45, 8'hF0}, "R9", 0);
        send('{8'h66, 8'h89, 8'h84, 8'h24, 8'h78, 8'h56, 8'h34, 8'h12}, "R5", 0);
        send('{8'h48, 8'h8B, 8'h05, 8'h44, 8'h33, 8'h22, 8'h11}, "R5", 0);
        send('{8'h66, 8'h48, 8'h01, 8'hC0}, "R5", 0);
        send('{8'h48, 8'h66, 8'h01, 8'hC0}, "R11", 0);
        send('{8'h04, 8'h80}, "R10", 0);
        send('{8'h66, 8'h05, 8'h34, 8'h92}, "R10", 0);
        send('{8'hC7, 8'h04, 8'h25, 8'h00, 8'h10, 8'h00, 8'h00, 8'h78, 8'h56, 8'h34, 8'h12}, "R9", 0);
        send('{8'h26, 8'h8A, 8'h5C, 8'h8B, 8'hFC}, "R4", 0);
        send('{8'h0F, 8'hAF, 8'hC1}, "R3", 0);
        send('{8'h0F, 8'h05}, "R3", 0);
        send('{8'hD6}, "R3", 0);
        send('{8'h90}, "R3", 0);
        send('{8'hF3, 8'hF2}, "R2", 0);
        send('{8'hF0, 8'h2E, 8'h66, 8'h67, 8'h48, 8'hC7, 8'h84, 8'h24,
               8'h01, 8'h02, 8'h03, 8'h04, 8'hAA, 8'hBB, 8'hCC}, "R12", 0);
        send('{8'h8B, 8'h45, 8'hF0}, "R13", 1);
        rexrun = {};
        for (int k = 0; k < 15; k++) rexrun.push_back(8'h40);
        send(rexrun, "R12", 0);
        send('{8'h41, 8'h8B, 8'h4C, 8'hD8, 8'h7F}, "R11", 0);
        @(posedge clk); #2;
        chk("R13", "single-cycle pulse", out_valid, 0);
        finish_run();
    end

endmodule